// File: doc/BRIEF.md
# Exception Entry Sequencer

This block moves a processor from normal execution into an exception handler. The core asserts a one-cycle raise strobe together with a 12-bit exception code. In the same cycle it presents its live status word, program counter, general register 15 and vector base address. On the next clock edge the sequencer latches the interrupted context into shadow registers. It also produces a status word with the handler-entry bits forced on, records an 11-bit event code and computes the handler entry address.

The handler address depends on the code. The three translation-miss codes jump to a miss-specific offset from the vector base. The translation multiple-hit code jumps to a fixed, reset-like address. Every other code uses the general offset from the vector base. For one cycle after each accepted strobe, a done pulse tells the fetch unit to redirect to the new program counter. The block does not arbitrate priority, handle return-from-exception or flush the pipeline. A strobe that arrives while the block bit is already set is accepted like any other, and software is responsible for nested entry.

Top module: `exc_entry_seq`

## Requirements
- R1: A synchronous active-high reset clears every output register to zero and drives done low.
- R2: On a raise, the saved-status, saved-PC and saved-GR outputs take the status word, program counter and general register 15 presented in the raise cycle, starting in the cycle after.
- R3: On a raise, the status output equals the presented status word with bit 28 (block), bit 29 (register bank) and bit 30 (privileged mode) forced to one and all other bits unchanged.
- R4: On a raise, the event output equals the low 11 bits of the exception code (code AND 0x7FF).
- R5: Codes 0x040, 0x060 and 0x080 (full 12-bit match) load the program-counter output with vector base plus 0x400, modulo 2^32.
- R6: Code 0x140 loads the program-counter output with the fixed address 0xA0000000, whatever the vector base.
- R7: Every other code, including codes that match a miss code only in their low 11 bits, loads vector base plus 0x100, modulo 2^32.
- R8: Done is high for exactly the cycle after each raise. Without a raise, done is low and all context outputs hold their values.
- R9: A raise is accepted even when bit 28 of the presented status word is already set, and it overwrites all saved registers.
- R10: Raises on consecutive cycles are each accepted. Done stays high for both following cycles, and the outputs show the second raise's context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_i | input | 1 | One-cycle exception raise strobe |
| code_i | input | 12 | Exception code |
| sr_i | input | 32 | Current status word |
| pc_i | input | 32 | Faulting program counter |
| gr15_i | input | 32 | Current general register 15 |
| vbase_i | input | 32 | Vector base address |
| sr_o | output | 32 | Status word after entry |
| pc_o | output | 32 | Handler entry address |
| ssr_o | output | 32 | Saved status word |
| spc_o | output | 32 | Saved program counter |
| sgr_o | output | 32 | Saved general register 15 |
| evt_o | output | 11 | Recorded event code |
| done_o | output | 1 | Redirect pulse, one cycle after a raise |

## Verification
The bench aims at the vector selection edges. Code 0x840 shares its low 11 bits with a miss code, so a design that decodes only the masked code would send it to the miss offset. A vector base near the top of the address space makes the general offset wrap to zero, and a design that saturates or widens the sum would show a wrong entry address. Two further cases are a status word with all bits already set and a strobe arriving with the block bit set. A design that gates acceptance on the block bit would keep the stale saved context. Back-to-back strobes and the hold cycles after each entry catch a done pulse that is stretched or missing, and saved registers that keep loading without a strobe.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int DATA_W   = 32;
    localparam int CODE_W   = 12;
    localparam int EVT_W    = 11;

    localparam int BLK_BIT  = 28;
    localparam int BANK_BIT = 29;
    localparam int PRIV_BIT = 30;

    localparam logic [CODE_W-1:0] CODE_MISS_RD  = 12'h040;
    localparam logic [CODE_W-1:0] CODE_MISS_WR  = 12'h060;
    localparam logic [CODE_W-1:0] CODE_FIRST_WR = 12'h080;
    localparam logic [CODE_W-1:0] CODE_MULTIHIT = 12'h140;

    localparam logic [DATA_W-1:0] OFS_MISS  = 32'h0000_0400;
    localparam logic [DATA_W-1:0] OFS_GEN   = 32'h0000_0100;
    localparam logic [DATA_W-1:0] ADDR_SAFE = 32'hA000_0000;

    typedef enum logic [1:0] {
        VK_GENERAL  = 2'd0,
        VK_TLB_MISS = 2'd1,
        VK_MULTIHIT = 2'd2
    } vec_kind_e;

    typedef struct packed {
        logic [DATA_W-1:0] sr;
        logic [DATA_W-1:0] pc;
        logic [DATA_W-1:0] gr;
    } ctx_t;

    function automatic vec_kind_e classify_code(logic [CODE_W-1:0] c);
        vec_kind_e k;
        case (c)
            CODE_MISS_RD, CODE_MISS_WR, CODE_FIRST_WR: k = VK_TLB_MISS;
            CODE_MULTIHIT:                             k = VK_MULTIHIT;
            default:                                   k = VK_GENERAL;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
    import exc_entry_pkg::*;
#(
    parameter int XLEN  = DATA_W,
    parameter int CW    = CODE_W
) (
    input  logic [CW-1:0]   code,
    input  logic [XLEN-1:0] vbase,
    output logic [XLEN-1:0] vec_pc
);
    vec_kind_e kind;

    always_comb begin
        kind = classify_code(CODE_W'(code));
        case (kind)
            VK_TLB_MISS: vec_pc = vbase + XLEN'(OFS_MISS);
            VK_MULTIHIT: vec_pc = XLEN'(ADDR_SAFE);
            default:     vec_pc = vbase + XLEN'(OFS_GEN);
        endcase
    end
endmodule

// File: rtl/exc_sr_update.sv
module exc_sr_update
    import exc_entry_pkg::*;
#(
    parameter int XLEN   = DATA_W,
    parameter int B_BLK  = BLK_BIT,
    parameter int B_BANK = BANK_BIT,
    parameter int B_PRIV = PRIV_BIT
) (
    input  logic [XLEN-1:0] sr_in,
    output logic [XLEN-1:0] sr_out
);
    logic [XLEN-1:0] force_mask;

    for (genvar i = 0; i < XLEN; i++) begin : g_mask
        if (i == B_BLK || i == B_BANK || i == B_PRIV) begin : g_set
            assign force_mask[i] = 1'b1;
        end else begin : g_keep
            assign force_mask[i] = 1'b0;
        end
    end

    assign sr_out = sr_in | force_mask;
endmodule

// File: rtl/exc_ctx_regs.sv
module exc_ctx_regs
    import exc_entry_pkg::*;
#(
    parameter int XLEN = DATA_W,
    parameter int EW   = EVT_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  ctx_t            ctx_in,
    input  logic [XLEN-1:0] sr_new,
    input  logic [XLEN-1:0] pc_new,
    input  logic [EW-1:0]   evt_new,
    output logic [XLEN-1:0] sr_q,
    output logic [XLEN-1:0] pc_q,
    output ctx_t            ctx_q,
    output logic [EW-1:0]   evt_q,
    output logic            done_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            pc_q   <= '0;
            ctx_q  <= '0;
            evt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= load;
            if (load) begin
                sr_q  <= sr_new;
                pc_q  <= pc_new;
                ctx_q <= ctx_in;
                evt_q <= evt_new;
            end
        end
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int XLEN = DATA_W,
    parameter int CW   = CODE_W,
    parameter int EW   = EVT_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            raise_i,
    input  logic [CW-1:0]   code_i,
    input  logic [XLEN-1:0] sr_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] gr15_i,
    input  logic [XLEN-1:0] vbase_i,
    output logic [XLEN-1:0] sr_o,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] ssr_o,
    output logic [XLEN-1:0] spc_o,
    output logic [XLEN-1:0] sgr_o,
    output logic [EW-1:0]   evt_o,
    output logic            done_o
);
    logic [XLEN-1:0] vec_pc;
    logic [XLEN-1:0] sr_entry;
    logic [EW-1:0]   evt_code;
    ctx_t            ctx_in;
    ctx_t            ctx_q;

    assign evt_code = code_i[EW-1:0];

    always_comb begin
        ctx_in    = '0;
        ctx_in.sr = DATA_W'(sr_i);
        ctx_in.pc = DATA_W'(pc_i);
        ctx_in.gr = DATA_W'(gr15_i);
    end

    exc_vec_sel #(.XLEN(XLEN), .CW(CW)) u_vec (
        .code   (code_i),
        .vbase  (vbase_i),
        .vec_pc (vec_pc)
    );

    exc_sr_update #(.XLEN(XLEN)) u_sr (
        .sr_in  (sr_i),
        .sr_out (sr_entry)
    );

    exc_ctx_regs #(.XLEN(XLEN), .EW(EW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .load    (raise_i),
        .ctx_in  (ctx_in),
        .sr_new  (sr_entry),
        .pc_new  (vec_pc),
        .evt_new (evt_code),
        .sr_q    (sr_o),
        .pc_q    (pc_o),
        .ctx_q   (ctx_q),
        .evt_q   (evt_o),
        .done_q  (done_o)
    );

    assign ssr_o = XLEN'(ctx_q.sr);
    assign spc_o = XLEN'(ctx_q.pc);
    assign sgr_o = XLEN'(ctx_q.gr);
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int XLEN = DATA_W,
    parameter int CW   = CODE_W,
    parameter int EW   = EVT_W
) (
    input logic            clk,
    input logic            rst,
    input logic            raise_i,
    input logic [CW-1:0]   code_i,
    input logic [XLEN-1:0] sr_i,
    input logic [XLEN-1:0] pc_i,
    input logic [XLEN-1:0] gr15_i,
    input logic [XLEN-1:0] vbase_i,
    input logic [XLEN-1:0] sr_o,
    input logic [XLEN-1:0] pc_o,
    input logic [XLEN-1:0] ssr_o,
    input logic [XLEN-1:0] spc_o,
    input logic [XLEN-1:0] sgr_o,
    input logic [EW-1:0]   evt_o,
    input logic            done_o
);
    localparam logic [XLEN-1:0] ENTRY_BITS =
        (XLEN'(1) << BLK_BIT) | (XLEN'(1) << BANK_BIT) | (XLEN'(1) << PRIV_BIT);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        raise_i |=> done_o);

    assert_no_done_R8: assert property (@(posedge clk) disable iff (rst)
        !raise_i |=> !done_o);

    assert_hold_ctx_R8: assert property (@(posedge clk) disable iff (rst)
        !raise_i |=> ($stable(pc_o) && $stable(ssr_o) && $stable(spc_o) &&
                      $stable(sgr_o) && $stable(sr_o) && $stable(evt_o)));

    assert_saves_R2: assert property (@(posedge clk) disable iff (rst)
        raise_i |=> (ssr_o == $past(sr_i) && spc_o == $past(pc_i) &&
                     sgr_o == $past(gr15_i)));

    assert_entry_bits_R3: assert property (@(posedge clk) disable iff (rst)
        raise_i |=> (((sr_o & ENTRY_BITS) == ENTRY_BITS) &&
                     ((sr_o & ~ENTRY_BITS) == ($past(sr_i) & ~ENTRY_BITS))));

    assert_event_R4: assert property (@(posedge clk) disable iff (rst)
        raise_i |=> (evt_o == $past(code_i[EW-1:0])));

    assert_miss_vec_R5: assert property (@(posedge clk) disable iff (rst)
        (raise_i && (code_i == 12'h040 || code_i == 12'h060 || code_i == 12'h080))
        |=> (pc_o == $past(vbase_i) + XLEN'(32'h400)));

    assert_fixed_vec_R6: assert property (@(posedge clk) disable iff (rst)
        (raise_i && code_i == 12'h140) |=> (pc_o == XLEN'(32'hA000_0000)));

    assert_general_vec_R7: assert property (@(posedge clk) disable iff (rst)
        (raise_i && code_i != 12'h040 && code_i != 12'h060 &&
         code_i != 12'h080 && code_i != 12'h140)
        |=> (pc_o == $past(vbase_i) + XLEN'(32'h100)));
endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN), .CW(CW), .EW(EW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .raise_i (raise_i),
    .code_i  (code_i),
    .sr_i    (sr_i),
    .pc_i    (pc_i),
    .gr15_i  (gr15_i),
    .vbase_i (vbase_i),
    .sr_o    (sr_o),
    .pc_o    (pc_o),
    .ssr_o   (ssr_o),
    .spc_o   (spc_o),
    .sgr_o   (sgr_o),
    .evt_o   (evt_o),
    .done_o  (done_o)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;

    typedef struct packed {
        logic [11:0] code;
        logic [31:0] sr;
        logic [31:0] pc;
        logic [31:0] gr;
        logic [31:0] vb;
        logic [31:0] exp_pc;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{12'h040, 32'h0000_0000, 32'h0000_1000, 32'h1111_1111, 32'h8C00_0000, 32'h8C00_0400},
        '{12'h060, 32'h0000_00F0, 32'h0000_2004, 32'h2222_2222, 32'h8C00_0000, 32'h8C00_0400},
        '{12'h080, 32'h0000_0003, 32'h0C00_0100, 32'h3333_3333, 32'h0001_0000, 32'h0001_0400},
        '{12'h140, 32'h4000_0001, 32'h0000_3000, 32'h4444_4444, 32'h8C00_0000, 32'hA000_0000},
        '{12'h0E0, 32'h0000_0700, 32'h1234_5678, 32'h5555_5555, 32'h8C00_0000, 32'h8C00_0100},
        '{12'h840, 32'h0000_0000, 32'h0000_4440, 32'h6666_6666, 32'h8C00_0000, 32'h8C00_0100},
        '{12'h0A0, 32'hFFFF_FFFF, 32'hFFFF_FFFC, 32'h7777_7777, 32'hFFFF_FF00, 32'h0000_0000},
        '{12'h160, 32'h1000_0000, 32'h0000_5550, 32'h8888_8888, 32'h0000_0000, 32'h0000_0100}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        raise_i = 1'b0;
    logic [11:0] code_i = '0;
    logic [31:0] sr_i = '0, pc_i = '0, gr15_i = '0, vbase_i = '0;
    logic [31:0] sr_o, pc_o, ssr_o, spc_o, sgr_o;
    logic [10:0] evt_o;
    logic        done_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    exc_entry_seq u_exc_entry_seq (
        .clk(clk), .rst(rst), .raise_i(raise_i), .code_i(code_i),
        .sr_i(sr_i), .pc_i(pc_i), .gr15_i(gr15_i), .vbase_i(vbase_i),
        .sr_o(sr_o), .pc_o(pc_o), .ssr_o(ssr_o), .spc_o(spc_o),
        .sgr_o(sgr_o), .evt_o(evt_o), .done_o(done_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [11:0] c, input logic [31:0] s, input logic [31:0] p,
                         input logic [31:0] g, input logic [31:0] v);
        raise_i = 1'b1; code_i = c; sr_i = s; pc_i = p; gr15_i = g; vbase_i = v;
    endtask

    task automatic scramble();
        raise_i = 1'b0; code_i = 12'h140; sr_i = 32'hDEAD_BEEF;
        pc_i = 32'hCAFE_F00D; gr15_i = 32'h0BAD_0BAD; vbase_i = 32'h5A5A_0000;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1: reset state
        check("R1 done", {31'd0, done_o}, 32'd0);
        check("R1 sr", sr_o, 32'd0);
        check("R1 pc", pc_o, 32'd0);
        check("R1 ssr", ssr_o, 32'd0);
        check("R1 evt", {21'd0, evt_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].code, VECS[i].sr, VECS[i].pc, VECS[i].gr, VECS[i].vb);
            @(negedge clk);
            scramble();
            check("R8 done high", {31'd0, done_o}, 32'd1);
            check("R5/R6/R7 vector", pc_o, VECS[i].exp_pc);
            check("R3 status", sr_o, VECS[i].sr | 32'h7000_0000);
            check("R4 event", {21'd0, evt_o}, {20'd0, VECS[i].code & 12'h7FF});
            check("R2 ssr", ssr_o, VECS[i].sr);
            check("R2 spc", spc_o, VECS[i].pc);
            check("R2 sgr", sgr_o, VECS[i].gr);
            if (i == 7) check("R9 accepted with block bit set", ssr_o, 32'h1000_0000);
            @(negedge clk);
            check("R8 done low", {31'd0, done_o}, 32'd0);
            check("R8 hold pc", pc_o, VECS[i].exp_pc);
            check("R8 hold spc", spc_o, VECS[i].pc);
        end

        // R10: back-to-back raises
        drive(12'h040, 32'h0, 32'h0000_AAA0, 32'h1, 32'h0000_2000);
        @(negedge clk);
        check("R10 first done", {31'd0, done_o}, 32'd1);
        check("R10 first pc", pc_o, 32'h0000_2400);
        drive(12'h140, 32'h1000_0000, 32'h0000_BBB0, 32'h2, 32'h0000_2000);
        @(negedge clk);
        scramble();
        check("R10 second done", {31'd0, done_o}, 32'd1);
        check("R10 second pc", pc_o, 32'hA000_0000);
        check("R10 second spc", spc_o, 32'h0000_BBB0);
        check("R9 overwrite sgr", sgr_o, 32'h2);
        @(negedge clk);
        check("R10 done ends", {31'd0, done_o}, 32'd0);

        // R1: reset after activity
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset pc", pc_o, 32'd0);
        check("R1 reset spc", spc_o, 32'd0);
        check("R1 reset sr", sr_o, 32'd0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule